// File: doc/BRIEF.md
# Coincidence-Count Signed Fraction Multiplier

This block multiplies two signed fractions without a multiplier array. Each operand is given in sign-magnitude form as an N-bit magnitude `m`, which stands for the value m/(2^N−1), plus a separate sign bit. A start strobe opens a time window of 2^N−1 clock cycles. During the window the first operand becomes a leading pulse: a line that is high for its first `m` slots. The second operand, the weight, becomes a sparse pattern. It has the same number of ones as its magnitude, spread evenly over the window and mirror-symmetric about the window centre. One AND gate compares the two streams in each slot. An up/down counter tallies the slots in which both streams are high. The XOR of the two sign bits sets the counting direction.

When the window closes, the counter holds the product, again as a fraction of 2^N−1, and a one-cycle done pulse marks it. The rounding of this method is part of its behaviour and is not corrected. Typical use is inside many small arithmetic cells that can trade 2^N−1 cycles of latency for a very small area.

Top module: `tw_and_mult`

## Requirements
- R1: Once the idle block samples start high on a rising edge, `busy` is high for the next 2^N−1 cycles, and `done` is high for exactly one cycle, seen after the (2^N−1)-th following rising edge.
- R2: The first operand with magnitude k is high in window slots 0 to k−1 and low in all later slots. With a weight magnitude of 2^N−1, the result therefore equals +k or −k.
- R3: The weight pattern comes from an accumulator that starts at floor((2^N−1)/2) and adds w in each slot. A slot holds a one when the sum reaches 2^N−1, and 2^N−1 is then subtracted. For N=3 and w=4 this gives 1010101.
- R4: The result magnitude is the number of slots in which both streams are high. For N=3, −3/7 × −4/7 gives +2 and −5/7 × 6/7 gives −4.
- R5: The counter counts up when a_sign XOR b_sign is 0 and down when it is 1. Sign bit 1 means negative.
- R6: `result` is a two's-complement value of N+1 bits. It is set to 0 at the start edge and keeps its final value after done until the next accepted start.
- R7: A start pulse that arrives while `busy` is high is ignored. The running product and its timing do not change.
- R8: A zero magnitude on either operand gives a result of exactly 0, whatever the sign bits are.
- R9: After reset, `result` is 0 and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; operands are latched when it is accepted |
| a_sign | input | 1 | Sign of the first operand (1 = negative) |
| a_mag | input | N | Magnitude of the first operand (leading-pulse code) |
| b_sign | input | 1 | Sign of the weight (1 = negative) |
| b_mag | input | N | Magnitude of the weight (spread code) |
| busy | output | 1 | High during the window slots |
| done | output | 1 | One-cycle pulse when the result is final |
| result | output | N+1 | Signed product, in units of 1/(2^N−1) |

## Verification
The weight pattern is never visible at the ports, so it has to be inferred. A first operand of full magnitude turns the result into a direct count of the weight's ones. A weight of full magnitude does the same for the leading-pulse length. Sweeping the first operand from 0 to 2^N−1 against a fixed weight then shows the pattern slot by slot, one result step at a time.

The hardest case to reach is a start strobe during a window. The bench drives one mid-window with different operands and then requires the first product and its timing to come out unchanged.

// File: rtl/tw_and_mult.sv
module tw_and_mult #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         a_sign,
  input  logic [N-1:0] a_mag,
  input  logic         b_sign,
  input  logic [N-1:0] b_mag,
  output logic         busy,
  output logic         done,
  output logic [N:0]   result
);
  localparam int WIN = (1 << N) - 1;
  localparam logic [N:0]   WIN_W  = (N+1)'(WIN);
  localparam logic [N:0]   HALF_W = (N+1)'(WIN / 2);
  localparam logic [N-1:0] LAST   = N'(WIN - 1);

  logic [N-1:0] slot;
  logic [N-1:0] ma_q, mb_q;
  logic         neg_q;
  logic [N:0]   acc;
  logic [N:0]   sum;
  logic         w_bit, x_bit, hit;

  assign sum   = acc + {1'b0, mb_q};
  assign w_bit = sum >= WIN_W;
  assign x_bit = slot < ma_q;
  assign hit   = busy & w_bit & x_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      slot   <= '0;
      ma_q   <= '0;
      mb_q   <= '0;
      neg_q  <= 1'b0;
      acc    <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          slot   <= '0;
          ma_q   <= a_mag;
          mb_q   <= b_mag;
          neg_q  <= a_sign ^ b_sign;
          acc    <= HALF_W;
          result <= '0;
        end
      end else begin
        acc <= w_bit ? sum - WIN_W : sum;
        if (hit)
          result <= neg_q ? result - 1'b1 : result + 1'b1;
        if (slot == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tw_and_mult_checks.sv
module tw_and_mult_checks #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N:0]   result,
  input logic [N-1:0] slot,
  input logic [N-1:0] ma_q,
  input logic [N-1:0] mb_q
);
  localparam int WIN = (1 << N) - 1;

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (result == '0 && busy));
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && slot != (N)'(WIN - 1)) |=> (busy && slot == $past(slot) + 1'b1));
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ma_q == '0 || mb_q == '0)) |-> result == '0);
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(result) <= WIN && $signed(result) >= -WIN));
endmodule

bind tw_and_mult tw_and_mult_checks #(.N(N)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .slot(slot), .ma_q(ma_q), .mb_q(mb_q)
);

// File: tb/tw_and_mult_bench.sv
module tw_and_mult_bench;
  localparam int N = 3;
  localparam int WIN = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [N-1:0] a_mag = '0, b_mag = '0;
  logic busy, done;
  logic [N:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tw_and_mult #(.N(N)) u_tw_and_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .a_sign(a_sign), .a_mag(a_mag),
    .b_sign(b_sign), .b_mag(b_mag), .busy(busy), .done(done), .result(result)
  );

  function automatic int expect_prod(bit as, int am, bit bs, int bm);
    int acc = WIN / 2;
    int cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      bit one;
      acc = acc + bm;
      one = acc >= WIN;
      if (one) acc = acc - WIN;
      if (one && i < am) cnt++;
    end
    return (as ^ bs) ? -cnt : cnt;
  endfunction

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic run_op(bit as, int am, bit bs, int bm, bit poke, string req);
    int cyc = 0;
    int e = expect_prod(as, am, bs, bm);
    @(negedge clk);
    a_sign = as; a_mag = N'(am); b_sign = bs; b_mag = N'(bm); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", int'(busy), 1);
    check("R6 cleared at start", int'($signed(result)), 0);
    while (!done && cyc < 4 * WIN) begin
      if (poke && cyc == 2) begin
        a_sign = ~as; a_mag = N'(WIN); b_sign = 1'b0; b_mag = N'(WIN); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check("R1 window length", cyc, WIN);
    check(req, int'($signed(result)), e);
    @(negedge clk);
    check("R1 done one cycle", int'(done), 0);
    check("R6 hold", int'($signed(result)), e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset result", int'(result), 0);
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset done", int'(done), 0);
    rst_n = 1'b1;

    run_op(1, 3, 1, 4, 0, "R4 -3*-4");
    check("R4 -3*-4 literal", int'($signed(result)), 2);
    run_op(1, 5, 0, 6, 0, "R4 -5*6");
    check("R4 -5*6 literal", int'($signed(result)), -4);
    for (int w = 0; w <= WIN; w++) run_op(0, WIN, 0, w, 0, "R3 weight count");
    for (int k = 0; k <= WIN; k++) run_op(0, k, 0, WIN, 0, "R2 pulse length");
    for (int k = 1; k <= WIN; k++) run_op(0, k, 0, 4, 0, "R3 pattern 1010101");
    run_op(0, 1, 1, 1, 0, "R5 up/down");
    run_op(1, 1, 1, 1, 0, "R5 up/down");
    run_op(1, 0, 0, 5, 0, "R8 zero a");
    run_op(0, 6, 1, 0, 0, "R8 zero b");
    run_op(1, 0, 1, 0, 0, "R8 neg zero");
    run_op(1, 6, 0, 5, 1, "R7 start ignored");

    repeat (3) @(negedge clk);
    check("R6 long hold", int'($signed(result)), expect_prod(1, 6, 0, 5));

    void'($urandom(32'd1234));
    for (int i = 0; i < 150; i++) begin
      int am = int'($urandom_range(WIN, 0));
      int bm = int'($urandom_range(WIN, 0));
      bit as = 1'($urandom);
      bit bs = 1'($urandom);
      run_op(as, am, bs, bm, 0, "R4 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule